// File: doc/BRIEF.md
# Raster Position and Blanking Timer

This block tracks the beam position of a 262-line video frame. A horizontal counter moves two master-clock units per enabled step, and the line counter and frame counter follow it. From the position the block works out the vertical-blanking window. The window starts at one of two lines, and which one depends on an overscan input sampled at the earlier line. The block sends one-cycle strobes to the neighbouring units: a transfer-table initialisation at the top of the frame, a line-render request in the middle of each visible line, and a per-line transfer request at the start of horizontal blanking.

A byte-wide register port holds the control byte and the two 9-bit horizontal/vertical interrupt compare values. It also returns three status bytes: the NMI flag, the IRQ flag, and a blanking/joypad-busy status. The two flag bytes clear on read. Any bit without a defined meaning is filled from the open-bus byte supplied by the system.

Top module: `raster_timer`

## Requirements
- R1: When step_i is high, h_pos_o advances by H_STEP. From H_TOTAL-H_STEP it wraps to 0 and v_pos_o increments. From V_TOTAL-1, v_pos_o wraps to 0 and frame_o increments. When step_i is low, the position does not change.
- R2: A step taken at h=0 on line 0 clears vblank_o and the NMI flag, and pulses hdma_init_o for one cycle.
- R3: Vertical blanking starts on a step at h=0 of line VBL_LINE if overscan_i is low in that cycle. Otherwise it starts on a step at h=0 of line VBL_LINE_OS, provided blanking has not already started.
- R4: When blanking starts, the NMI flag is set. If control bit 7 (NMI enable) is set, nmi_req_o also pulses for one cycle.
- R5: A step at h=H_RENDER on a line outside blanking pulses render_o, with render_line_o set to that line. A step at h=H_XFER outside blanking pulses hdma_xfer_o.
- R6: Offset 0x12 reads {vblank, h>=H_XFER, open_bus[5:1], joypad busy}, with bit 7 first.
- R7: Offset 0x10 reads {NMI flag, open_bus[6:4], 4'h2}. The read clears the NMI flag unless blanking starts in the same cycle.
- R8: Offset 0x11 reads {IRQ flag, open_bus[6:0]}. The read clears the flag and irq_req_o unless a timer match occurs in the same cycle.
- R9: The H and V compare values are 9 bits wide and reset to 0x1FF. Offsets 0x07 and 0x09 write the low byte of H and V. Offsets 0x08 and 0x0A write bit 8 from data bit 0.
- R10: Writing offset 0x00 with bits 4 and 5 both clear forces the IRQ flag and irq_req_o low in the next cycle.
- R11: The IRQ flag is set when a step matches the enabled compare. With H only (bit 4): h%4==0 and h/4 equal to the H value. With V only (bit 5): line equal to the V value at h=0. With both: both conditions together.
- R12: When blanking starts with control bit 0 set, the joypad-busy counter loads AJ_STEPS. It then decrements once per step until it reaches zero. Writing offset 0x00 with bit 0 clear zeroes the counter.
- R13: Any other read offset returns open_bus_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| step_i | input | 1 | position advance enable |
| overscan_i | input | 1 | selects the late blanking line |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe (side effects) |
| reg_addr_i | input | 5 | register offset |
| reg_wdata_i | input | 8 | write data |
| open_bus_i | input | 8 | filler for undefined bits |
| reg_rdata_o | output | 8 | combinational read data |
| h_pos_o | output | HW | horizontal counter |
| v_pos_o | output | VW | line counter |
| frame_o | output | FW | frame counter |
| vblank_o | output | 1 | vertical blanking flag |
| nmi_req_o | output | 1 | NMI request pulse |
| irq_req_o | output | 1 | IRQ request level |
| hdma_init_o | output | 1 | top-of-frame strobe |
| render_o | output | 1 | line render strobe |
| render_line_o | output | VW | line of the render strobe |
| hdma_xfer_o | output | 1 | per-line transfer strobe |

## Verification
The bench runs a reduced frame geometry, so that several whole frames fit in the run. The step enable is driven every cycle, every second cycle and every third cycle, which separates per-step behaviour from per-cycle behaviour. Frames are run with overscan low, with overscan high, and with overscan changing mid-frame, which shows whether the blanking line is chosen at the right moment. The interrupt compare is tried with H only, V only and both enabled, with the timer left at its reset value and then partly and fully written. Reads of the flag bytes are placed at moving times, so that clear-on-read is seen both before and after events.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_HT_LO  = 5'h07;
  localparam logic [4:0] OFS_HT_HI  = 5'h08;
  localparam logic [4:0] OFS_VT_LO  = 5'h09;
  localparam logic [4:0] OFS_VT_HI  = 5'h0A;
  localparam logic [4:0] OFS_NMI_RD = 5'h10;
  localparam logic [4:0] OFS_IRQ_RD = 5'h11;
  localparam logic [4:0] OFS_STAT   = 5'h12;
  localparam logic [3:0] CHIP_REV   = 4'h2;

  typedef struct packed {
    logic nmi_en;
    logic v_en;
    logic h_en;
    logic aj_en;
  } ctrl_t;
endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int H_TOTAL = 1364,
  parameter int H_STEP  = 2,
  parameter int V_TOTAL = 262,
  parameter int FW      = 16,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic [FW-1:0] frame_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - H_STEP);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
      v_o <= '0;
      frame_o <= '0;
    end else if (step_i) begin
      if (h_o == H_LAST) begin
        h_o <= '0;
        if (v_o == V_LAST) begin
          v_o <= '0;
          frame_o <= frame_o + 1'b1;
        end else begin
          v_o <= v_o + 1'b1;
        end
      end else begin
        h_o <= h_o + HW'(H_STEP);
      end
    end
  end

  assert_h_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(h_o) < H_TOTAL) && (32'(v_o) < V_TOTAL));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(h_o) && $stable(v_o));
endmodule

// File: rtl/raster_events.sv
module raster_events #(
  parameter int H_TOTAL     = 1364,
  parameter int V_TOTAL     = 262,
  parameter int VBL_LINE    = 225,
  parameter int VBL_LINE_OS = 240,
  parameter int H_RENDER    = 512,
  parameter int H_XFER      = 1024,
  parameter int AJ_STEPS    = 2112,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int AW = $clog2(AJ_STEPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          overscan_i,
  input  logic          aj_en_i,
  input  logic          nmi_en_i,
  input  logic          aj_clr_i,
  input  logic          nmi_rd_i,
  output logic          vblank_o,
  output logic          nmi_flag_o,
  output logic          nmi_req_o,
  output logic          hdma_init_o,
  output logic          render_o,
  output logic [VW-1:0] render_line_o,
  output logic          hdma_xfer_o,
  output logic          aj_busy_o
);
  logic          line_top, vbl_start;
  logic [AW-1:0] aj_cnt;

  assign line_top  = step_i && (h_i == '0) && (v_i == '0);
  assign vbl_start = step_i && (h_i == '0) &&
                     (((32'(v_i) == VBL_LINE) && !overscan_i) ||
                      ((32'(v_i) == VBL_LINE_OS) && !vblank_o));
  assign aj_busy_o = (aj_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vblank_o      <= 1'b0;
      nmi_flag_o    <= 1'b0;
      nmi_req_o     <= 1'b0;
      hdma_init_o   <= 1'b0;
      render_o      <= 1'b0;
      render_line_o <= '0;
      hdma_xfer_o   <= 1'b0;
      aj_cnt        <= '0;
    end else begin
      hdma_init_o <= line_top;
      nmi_req_o   <= vbl_start && nmi_en_i;
      render_o    <= step_i && (32'(h_i) == H_RENDER) && !vblank_o;
      hdma_xfer_o <= step_i && (32'(h_i) == H_XFER) && !vblank_o;
      if (step_i && (32'(h_i) == H_RENDER) && !vblank_o) render_line_o <= v_i;
      if (line_top) vblank_o <= 1'b0;
      else if (vbl_start) vblank_o <= 1'b1;
      if (vbl_start) nmi_flag_o <= 1'b1;
      else if (line_top || nmi_rd_i) nmi_flag_o <= 1'b0;
      if (aj_clr_i) aj_cnt <= '0;
      else if (vbl_start && aj_en_i) aj_cnt <= AW'(AJ_STEPS);
      else if (step_i && aj_busy_o) aj_cnt <= aj_cnt - 1'b1;
    end
  end

  assert_top_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdma_init_o |-> !vblank_o && !nmi_flag_o);
  assert_vbl_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vblank_o) |-> (32'(v_i) == VBL_LINE) || (32'(v_i) == VBL_LINE_OS));
  assert_nmi_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> vblank_o && nmi_flag_o);
  assert_no_render_vbl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_o || hdma_xfer_o) |-> !vblank_o);
endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int H_TOTAL = 1364,
  parameter int V_TOTAL = 262,
  parameter int H_XFER  = 1024,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [4:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic [7:0]    open_bus_i,
  input  logic          vblank_i,
  input  logic          nmi_flag_i,
  input  logic          aj_busy_i,
  output ctrl_t         ctrl_o,
  output logic          irq_o,
  output logic [7:0]    rdata_o
);
  logic [8:0] h_cmp, v_cmp;
  logic       wr_ctrl, dot_hit, line_hit, irq_set, irq_kill;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == OFS_CTRL);
  assign irq_kill = wr_ctrl && (reg_wdata_i[5:4] == 2'b00);
  assign dot_hit  = (h_i[1:0] == 2'b00) && ((32'(h_i) >> 2) == 32'(h_cmp));
  assign line_hit = (32'(v_i) == 32'(v_cmp));

  always_comb begin
    unique case ({ctrl_o.v_en, ctrl_o.h_en})
      2'b11:   irq_set = dot_hit && line_hit;
      2'b01:   irq_set = dot_hit;
      2'b10:   irq_set = line_hit && (h_i == '0);
      default: irq_set = 1'b0;
    endcase
    irq_set = irq_set && step_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      h_cmp  <= 9'h1FF;
      v_cmp  <= 9'h1FF;
      irq_o  <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        unique case (reg_addr_i)
          OFS_CTRL:  ctrl_o <= '{nmi_en: reg_wdata_i[7], v_en: reg_wdata_i[5],
                                 h_en: reg_wdata_i[4], aj_en: reg_wdata_i[0]};
          OFS_HT_LO: h_cmp[7:0] <= reg_wdata_i;
          OFS_HT_HI: h_cmp[8]   <= reg_wdata_i[0];
          OFS_VT_LO: v_cmp[7:0] <= reg_wdata_i;
          OFS_VT_HI: v_cmp[8]   <= reg_wdata_i[0];
          default: ;
        endcase
      end
      if (irq_kill) irq_o <= 1'b0;
      else if (irq_set) irq_o <= 1'b1;
      else if (reg_rd_i && (reg_addr_i == OFS_IRQ_RD)) irq_o <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_NMI_RD: rdata_o = {nmi_flag_i, open_bus_i[6:4], CHIP_REV};
      OFS_IRQ_RD: rdata_o = {irq_o, open_bus_i[6:0]};
      OFS_STAT:   rdata_o = {vblank_i, (32'(h_i) >= H_XFER), open_bus_i[5:1], aj_busy_i};
      default:    rdata_o = open_bus_i;
    endcase
  end

  assert_irq_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == OFS_CTRL && reg_wdata_i[5:4] == 2'b00) |=> !irq_o);
  assert_irq_rdclr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFS_IRQ_RD && !step_i) |=> !irq_o);
  assert_irq_needs_en_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ctrl_o.h_en || ctrl_o.v_en));
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int H_TOTAL     = 1364,
  parameter int H_STEP      = 2,
  parameter int V_TOTAL     = 262,
  parameter int VBL_LINE    = 225,
  parameter int VBL_LINE_OS = 240,
  parameter int H_RENDER    = 512,
  parameter int H_XFER      = 1024,
  parameter int AJ_STEPS    = 2112,
  parameter int FW          = 16,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          overscan_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [4:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic [7:0]    open_bus_i,
  output logic [7:0]    reg_rdata_o,
  output logic [HW-1:0] h_pos_o,
  output logic [VW-1:0] v_pos_o,
  output logic [FW-1:0] frame_o,
  output logic          vblank_o,
  output logic          nmi_req_o,
  output logic          irq_req_o,
  output logic          hdma_init_o,
  output logic          render_o,
  output logic [VW-1:0] render_line_o,
  output logic          hdma_xfer_o
);
  ctrl_t ctrl;
  logic  nmi_flag, aj_busy, aj_clr, nmi_rd;

  assign aj_clr = reg_wr_i && (reg_addr_i == OFS_CTRL) && !reg_wdata_i[0];
  assign nmi_rd = reg_rd_i && (reg_addr_i == OFS_NMI_RD);

  raster_counter #(.H_TOTAL(H_TOTAL), .H_STEP(H_STEP), .V_TOTAL(V_TOTAL), .FW(FW)) u_cnt (
    .clk_i, .rst_ni, .step_i, .h_o(h_pos_o), .v_o(v_pos_o), .frame_o(frame_o));

  raster_events #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .VBL_LINE(VBL_LINE),
    .VBL_LINE_OS(VBL_LINE_OS), .H_RENDER(H_RENDER), .H_XFER(H_XFER),
    .AJ_STEPS(AJ_STEPS)) u_evt (
    .clk_i, .rst_ni, .step_i, .h_i(h_pos_o), .v_i(v_pos_o), .overscan_i,
    .aj_en_i(ctrl.aj_en), .nmi_en_i(ctrl.nmi_en), .aj_clr_i(aj_clr), .nmi_rd_i(nmi_rd),
    .vblank_o, .nmi_flag_o(nmi_flag), .nmi_req_o, .hdma_init_o, .render_o,
    .render_line_o, .hdma_xfer_o, .aj_busy_o(aj_busy));

  raster_regs #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_XFER(H_XFER)) u_regs (
    .clk_i, .rst_ni, .step_i, .h_i(h_pos_o), .v_i(v_pos_o), .reg_wr_i, .reg_rd_i,
    .reg_addr_i, .reg_wdata_i, .open_bus_i, .vblank_i(vblank_o), .nmi_flag_i(nmi_flag),
    .aj_busy_i(aj_busy), .ctrl_o(ctrl), .irq_o(irq_req_o), .rdata_o(reg_rdata_o));
endmodule

// File: tb/raster_timer_bench.sv
module raster_timer_bench;
  localparam int HT = 40, VT = 20, VL = 12, VLO = 16, HR = 16, HX = 28, AJ = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       step = 0, ovs = 0, wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [7:0] wd = '0, ob = '0;
  logic [7:0] rdata;
  logic [5:0] h_pos;
  logic [4:0] v_pos, rline;
  logic [15:0] frame;
  logic vbl, nmi_req, irq_req, hinit, rend, xfer;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int mh = 0, mv = 0, mframe = 0, maj = 0, mht = 'h1FF, mvt = 'h1FF;
  bit mvbl = 0, mnmif = 0, mirq = 0, m_aj_en = 0, m_h_en = 0, m_v_en = 0, m_nmi_en = 0;
  bit p_nmi = 0, p_init = 0, p_rend = 0, p_xfer = 0;
  int mrline = 0;

  always #5 clk = ~clk;

  raster_timer #(.H_TOTAL(HT), .V_TOTAL(VT), .VBL_LINE(VL), .VBL_LINE_OS(VLO),
    .H_RENDER(HR), .H_XFER(HX), .AJ_STEPS(AJ)) u_raster_timer (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .overscan_i(ovs), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wd), .open_bus_i(ob),
    .reg_rdata_o(rdata), .h_pos_o(h_pos), .v_pos_o(v_pos), .frame_o(frame),
    .vblank_o(vbl), .nmi_req_o(nmi_req), .irq_req_o(irq_req), .hdma_init_o(hinit),
    .render_o(rend), .render_line_o(rline), .hdma_xfer_o(xfer));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      'h10: return (int'(mnmif) << 7) | (ob & 'h70) | 2;
      'h11: return (int'(mirq) << 7) | (ob & 'h7F);
      'h12: return (int'(mvbl) << 7) | (int'(mh >= HX) << 6) | (ob & 'h3E) | int'(maj != 0);
      default: return ob;
    endcase
  endfunction

  task automatic model_edge();
    bit top, start, hm, vm, iset, kill;
    p_init = 0; p_nmi = 0; p_rend = 0; p_xfer = 0;
    top   = step && mh == 0 && mv == 0;
    start = step && mh == 0 && ((mv == VL && !ovs) || (mv == VLO && !mvbl));
    if (step && !mvbl && mh == HR) begin p_rend = 1; mrline = mv; end
    if (step && !mvbl && mh == HX) p_xfer = 1;
    p_init = top;
    p_nmi  = start && m_nmi_en;
    if (wr && addr == 0 && !wd[0]) maj = 0;
    else if (start && m_aj_en) maj = AJ;
    else if (step && maj > 0) maj--;
    if (start) mnmif = 1;
    else if (top || (rd && addr == 'h10)) mnmif = 0;
    hm = (mh % 4 == 0) && (mh / 4 == mht);
    vm = (mv == mvt);
    if (m_h_en && m_v_en) iset = hm && vm;
    else if (m_h_en) iset = hm;
    else if (m_v_en) iset = vm && mh == 0;
    else iset = 0;
    iset = iset && step;
    kill = wr && addr == 0 && wd[5:4] == 0;
    if (kill) mirq = 0;
    else if (iset) mirq = 1;
    else if (rd && addr == 'h11) mirq = 0;
    if (top) mvbl = 0; else if (start) mvbl = 1;
    if (wr) case (addr)
      0: begin m_nmi_en = wd[7]; m_v_en = wd[5]; m_h_en = wd[4]; m_aj_en = wd[0]; end
      7: mht = (mht & 'h100) | wd;
      8: mht = (mht & 'hFF) | (int'(wd[0]) << 8);
      9: mvt = (mvt & 'h100) | wd;
      10: mvt = (mvt & 'hFF) | (int'(wd[0]) << 8);
      default: ;
    endcase
    if (step) begin
      mh += 2;
      if (mh == HT) begin
        mh = 0; mv++;
        if (mv == VT) begin mv = 0; mframe = (mframe + 1) & 'hFFFF; end
      end
    end
  endtask

  task automatic compare_outs();
    chk("R1", "h_pos", h_pos, mh);
    chk("R1", "v_pos", v_pos, mv);
    chk("R1", "frame", frame, mframe);
    chk("R3", "vblank", vbl, mvbl);
    chk("R4", "nmi_req", nmi_req, p_nmi);
    chk("R2", "hdma_init", hinit, p_init);
    chk("R5", "render", rend, p_rend);
    if (p_rend) chk("R5", "render_line", rline, mrline);
    chk("R5", "hdma_xfer", xfer, p_xfer);
    chk("R11", "irq_req", irq_req, mirq);
  endtask

  task automatic tick(bit s, bit w, bit r, int a, int d);
    step = s; wr = w; rd = r; addr = 5'(a); wd = 8'(d); ob = 8'(cyc * 37 + 11);
    #1;
    chk(a == 'h10 ? "R7" : a == 'h11 ? "R8" : a == 'h12 ? "R6" : "R13",
        "rdata", rdata, exp_rd(a));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    compare_outs();
  endtask

  task automatic wreg(int a, int d);
    tick(1, 1, 0, a, d);
  endtask

  task automatic run(int n, int sp, int rp, int ra);
    for (int i = 0; i < n; i++)
      tick((i % sp) == 0, 0, rp != 0 && (i % rp) == rp - 1, ra, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: R1 counters, R9 timers at 0x1FF observed via IRQ later
    chk("R1", "reset h", h_pos, 0);
    chk("R3", "reset vblank", vbl, 0);
    chk("R8", "reset irq", irq_req, 0);
    wreg(0, 'h81);                 // R4 R12: NMI enable + joypad auto-read
    run(450, 1, 13, 'h12);         // R6 status while blanking starts at VL
    ovs = 1;
    run(900, 2, 29, 'h10);         // R3 overscan frame, R7 clear-on-read
    ovs = 0;
    run(300, 1, 17, 'h05);         // R13 open bus
    wreg(0, 'h11);                 // H-only, timer still 0x1FF: no IRQ (R9)
    run(100, 1, 0, 0);
    wreg(7, 5);                    // R9 low byte only, bit 8 still set
    run(100, 1, 0, 0);
    wreg(8, 0);                    // R9 bit 8 cleared -> dot 5 matches
    run(200, 1, 23, 'h11);         // R11 R8
    wreg(9, 3); wreg(10, 0); wreg(0, 'h21);
    run(500, 1, 31, 'h11);         // R11 V-only
    wreg(9, 5); wreg(7, 2); wreg(0, 'h31);
    run(450, 1, 0, 0);             // R11 H and V
    wreg(0, 'h01);                 // R10 both clear drops IRQ
    run(20, 1, 0, 0);
    wreg(0, 'h80);                 // R12 auto-read off zeroes busy
    run(50, 1, 7, 'h12);
    wreg(0, 'h81);
    for (int k = 0; k < 4; k++) begin
      run(160, 3, 7, 'h12);
      ovs = ~ovs;                  // R3 overscan changing mid-frame
    end
    run(400, 1, 11, 'h10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule